// File: doc/BRIEF.md
# Processor Data Bus Drive Controller

This block sits on the processor side of a 64-bit bidirectional data bus. It decides when the bus is driven, held, advanced or released, and it captures read data. The core starts a bus cycle by pulling the active-low address strobe low. With the strobe it supplies a descriptor for the cycle: read or write, single or four-beat burst, and whether the cycle is pipelined behind one already in progress. For writes the core also supplies four 64-bit data words and eight active-low byte enables. The controller latches all of these when it accepts the strobe.

Each ready from the system (active-low `brdy_n`) completes one beat of the current cycle. In a write, each ready advances the driven word. In a read, each ready captures the bus input. A write queued behind a read does not drive the bus until one edge after the read's last ready has been sampled, so the two cycles never contend for the bus. A back-off request releases the bus at once and aborts all work in progress. A hold request is granted with a hold acknowledge only when no cycle is outstanding.

Cycle numbering used below: "after edge k" means the clock cycle that follows rising edge k.

Top module: `dbus_drive_ctrl`

## Requirements
- R1: After reset: `bus_oe`=0, `hlda`=0, `rd_valid`=0, `beat_cnt`=0, `bus_be_n`=8'hFF, and no cycle is outstanding.
- R2: A write strobe accepted at edge k starts the write.
  - The strobe is accepted when the controller is idle, `hlda`=0, `hold`=0 and `boff_n`=1.
  - `bus_oe` is still 0 after edge k and goes to 1 after edge k+1.
  - `bus_dout` then shows word 0, which is `cyc_words[63:0]`.
  - `bus_be_n` shows the `cyc_be_n` value latched at edge k.
- R3: While `bus_oe`=1 and no ready is sampled, `bus_dout` and `bus_be_n` hold their values. A single write ends at the first edge where `brdy_n`=0 is sampled with `bus_oe`=1, and `bus_oe` is 0 after that edge.
- R4: In a burst write, beat i drives `cyc_words[64*i +: 64]`, with i from 0 to 3. Each sampled ready advances to the next word and to the next `beat_cnt` value. After the fourth ready, `bus_oe` is 0 and `beat_cnt` is 0.
- R5: In a read, `bus_in` is captured into `rd_data` at each edge where a ready is sampled. `rd_valid` is 1 for exactly the following cycle. A single read takes one ready and a burst read takes four. `beat_cnt` shows the index of the beat being waited for.
- R6: Pipelined strobes and the queue slot:
  - While a cycle is outstanding, a strobe with `cyc_pipe`=1 is stored in a one-entry queue, provided the queue is free.
  - The stored cycle becomes current at the edge that completes the current cycle. A queued write promoted at edge j drives from after edge j+1.
  - While a cycle is outstanding, a strobe with `cyc_pipe`=0 is ignored.
- R7: Bus drive and contention:
  - `bus_oe` is 1 only while a write is in its drive phase.
  - `bus_dout` is all zeros whenever `bus_oe`=0.
  - `bus_oe` is 0 in the cycle after any read capture.
- R8: Back-off:
  - `boff_n`=0 sampled at edge k gives `bus_oe`=0 and `beat_cnt`=0 after edge k.
  - The current cycle and any queued cycle are dropped.
  - Strobes and readies sampled while `boff_n`=0 are ignored.
- R9: Hold:
  - `hlda` rises after an edge where `hold`=1 is sampled and no cycle is outstanding, and it stays 1 while `hold` stays 1.
  - `hlda` falls after the first edge where `hold`=0 is sampled.
  - A strobe is ignored at the granting edge and while `hlda`=1.
  - `bus_oe`=0 whenever `hlda`=1.
- R10: A ready sampled while idle, or in the launch cycle of a write (before `bus_oe` rises), is ignored. It causes no `rd_valid` and ends no cycle.
- R11: `bus_be_n` is 8'hFF whenever no cycle is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ads_n | input | 1 | Active-low address strobe starting a cycle |
| brdy_n | input | 1 | Active-low ready completing one beat |
| boff_n | input | 1 | Active-low back-off, aborts and floats |
| hold | input | 1 | Bus hold request |
| cyc_write | input | 1 | Descriptor: 1 write, 0 read |
| cyc_burst | input | 1 | Descriptor: 1 four-beat burst, 0 single |
| cyc_pipe | input | 1 | Descriptor: strobe is pipelined behind the current cycle |
| cyc_be_n | input | 8 | Active-low byte enables of the cycle |
| cyc_words | input | 256 | Four write words, word i at bits 64*i+63..64*i |
| bus_in | input | 64 | Data bus as seen from the pins |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 64 | Data word driven onto the bus |
| bus_be_n | output | 8 | Byte enables of the current cycle |
| rd_data | output | 64 | Last captured read word |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_data |
| beat_cnt | output | 2 | Index of the beat in progress |
| hlda | output | 1 | Hold acknowledge |

## Verification
Some rules are checked on every cycle, whatever the stimulus:
- the bus is released after back-off;
- the bus stays off while hold is acknowledged and in the cycle after a read capture;
- driven data and byte enables stay stable until a ready arrives;
- every drive phase starts at beat 0;
- `rd_valid` is always preceded by a ready.

Other behaviour can only be shown by the bench's scenarios. These cover the word order of a burst, the one-edge turnaround before a write queued behind a burst read, the dropping of non-pipelined strobes and of strobes seen during back-off, a hold deferred until a read completes, and readies ignored in the launch cycle.

// File: rtl/dbus_pkg.sv
`timescale 1ns/1ps
package dbus_pkg;

    localparam int unsigned DBUS_W = 64;
    localparam int unsigned BE_W   = DBUS_W / 8;
    localparam int unsigned BEATS  = 4;
    localparam int unsigned BEAT_W = $clog2(BEATS);
    localparam int unsigned WORDS_W = BEATS * DBUS_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_DRIVE  = 2'd2,
        PH_READ   = 2'd3
    } phase_e;

    typedef struct packed {
        logic               is_wr;
        logic               is_burst;
        logic [BE_W-1:0]    be_n;
        logic [WORDS_W-1:0] words;
    } cyc_desc_t;

    // Phase a cycle enters when it becomes current.
    function automatic phase_e entry_phase(input cyc_desc_t d);
        return d.is_wr ? PH_LAUNCH : PH_READ;
    endfunction

    // True when the ready for this beat completes the cycle.
    function automatic logic beat_is_last(input logic is_burst,
                                          input logic [BEAT_W-1:0] beat);
        return !is_burst || (beat == BEAT_W'(BEATS - 1));
    endfunction

endpackage

// File: rtl/dbus_beat_ctr.sv
`timescale 1ns/1ps
module dbus_beat_ctr #(
    parameter int unsigned BEATS = 4,
    localparam int unsigned CW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] beat
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            beat <= '0;
        end else if (adv) begin
            beat <= beat + CW'(1);
        end
    end
endmodule

// File: rtl/dbus_rd_capture.sv
`timescale 1ns/1ps
module dbus_rd_capture #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= cap;
            if (cap) begin
                q <= din;
            end
        end
    end
endmodule

// File: rtl/dbus_wr_mux.sv
`timescale 1ns/1ps
module dbus_wr_mux #(
    parameter int unsigned W     = 64,
    parameter int unsigned BEATS = 4,
    localparam int unsigned CW = $clog2(BEATS)
) (
    input  logic [BEATS*W-1:0] words,
    input  logic [CW-1:0]      beat,
    input  logic               en,
    output logic [W-1:0]       dout
);
    logic [W-1:0] slot [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        assign slot[g] = words[g*W +: W];
    end

    assign dout = en ? slot[beat] : '0;
endmodule

// File: rtl/dbus_drive_ctrl.sv
`timescale 1ns/1ps
module dbus_drive_ctrl
    import dbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ads_n,
    input  logic               brdy_n,
    input  logic               boff_n,
    input  logic               hold,
    input  logic               cyc_write,
    input  logic               cyc_burst,
    input  logic               cyc_pipe,
    input  logic [BE_W-1:0]    cyc_be_n,
    input  logic [WORDS_W-1:0] cyc_words,
    input  logic [DBUS_W-1:0]  bus_in,
    output logic               bus_oe,
    output logic [DBUS_W-1:0]  bus_dout,
    output logic [BE_W-1:0]    bus_be_n,
    output logic [DBUS_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [BEAT_W-1:0]  beat_cnt,
    output logic               hlda
);
    phase_e    phase_q, phase_d;
    cyc_desc_t cur_q, cur_d;
    cyc_desc_t pend_q, pend_d;
    logic      pend_v_q, pend_v_d;
    logic      hlda_q;
    cyc_desc_t new_desc;

    logic backoff, idle, ads_ok, take_pipe, brdy_ok, finishing;

    assign new_desc = '{is_wr: cyc_write, is_burst: cyc_burst,
                        be_n: cyc_be_n, words: cyc_words};

    assign backoff   = !boff_n;
    assign idle      = (phase_q == PH_IDLE);
    // Hold wins over a strobe on the granting edge.
    assign ads_ok    = !ads_n && !backoff && !hlda_q && !(hold && idle);
    assign take_pipe = ads_ok && !idle && cyc_pipe && !pend_v_q;
    assign brdy_ok   = !brdy_n && !backoff &&
                       (phase_q == PH_DRIVE || phase_q == PH_READ);
    assign finishing = brdy_ok && beat_is_last(cur_q.is_burst, beat_cnt);

    always_comb begin
        phase_d  = phase_q;
        cur_d    = cur_q;
        pend_d   = pend_q;
        pend_v_d = pend_v_q;
        if (backoff) begin
            phase_d  = PH_IDLE;
            pend_v_d = 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (ads_ok) begin
                        cur_d   = new_desc;
                        phase_d = entry_phase(new_desc);
                    end
                end
                PH_LAUNCH: begin
                    // Turnaround edge: the bus is enabled on the next edge.
                    phase_d = PH_DRIVE;
                    if (take_pipe) begin
                        pend_d   = new_desc;
                        pend_v_d = 1'b1;
                    end
                end
                default: begin
                    if (finishing) begin
                        if (pend_v_q) begin
                            cur_d    = pend_q;
                            phase_d  = entry_phase(pend_q);
                            pend_v_d = 1'b0;
                        end else if (take_pipe) begin
                            cur_d   = new_desc;
                            phase_d = entry_phase(new_desc);
                        end else begin
                            phase_d = PH_IDLE;
                        end
                    end else if (take_pipe) begin
                        pend_d   = new_desc;
                        pend_v_d = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cur_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            hlda_q   <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            cur_q    <= cur_d;
            pend_q   <= pend_d;
            pend_v_q <= pend_v_d;
            hlda_q   <= hold && (hlda_q || idle);
        end
    end

    dbus_beat_ctr #(.BEATS(BEATS)) i_beat (
        .clk  (clk),
        .rst  (rst),
        .clr  (backoff || finishing),
        .adv  (brdy_ok && !finishing),
        .beat (beat_cnt)
    );

    dbus_rd_capture #(.W(DBUS_W)) i_rdcap (
        .clk (clk),
        .rst (rst),
        .cap (brdy_ok && (phase_q == PH_READ)),
        .din (bus_in),
        .q   (rd_data),
        .vld (rd_valid)
    );

    assign bus_oe = (phase_q == PH_DRIVE);

    dbus_wr_mux #(.W(DBUS_W), .BEATS(BEATS)) i_wmux (
        .words (cur_q.words),
        .beat  (beat_cnt),
        .en    (bus_oe),
        .dout  (bus_dout)
    );

    assign bus_be_n = idle ? '1 : cur_q.be_n;
    assign hlda     = hlda_q;

endmodule

// File: rtl/dbus_drive_chk.sv
`timescale 1ns/1ps
module dbus_drive_chk
    import dbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              brdy_n,
    input logic              boff_n,
    input logic              hold,
    input logic              bus_oe,
    input logic [DBUS_W-1:0] bus_dout,
    input logic [BE_W-1:0]   bus_be_n,
    input logic              rd_valid,
    input logic [BEAT_W-1:0] beat_cnt,
    input logic              hlda
);
    AST_BOFF_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !boff_n |=> !bus_oe);                                         // R8
    AST_BOFF_BEAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !boff_n |=> beat_cnt == '0);                                  // R8
    AST_HLDA_FLOATS: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !bus_oe);                                            // R9
    AST_HLDA_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> $past(hold));                                 // R9
    AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !bus_oe);                                        // R7
    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_dout == '0);                                  // R7
    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_oe && brdy_n && boff_n |=>
            bus_oe && $stable(bus_dout) && $stable(bus_be_n));        // R3
    AST_DRIVE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> beat_cnt == '0);                            // R4
    AST_RDV_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!brdy_n));                                 // R5
endmodule

bind dbus_drive_ctrl dbus_drive_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .brdy_n   (brdy_n),
    .boff_n   (boff_n),
    .hold     (hold),
    .bus_oe   (bus_oe),
    .bus_dout (bus_dout),
    .bus_be_n (bus_be_n),
    .rd_valid (rd_valid),
    .beat_cnt (beat_cnt),
    .hlda     (hlda)
);

// File: tb/test_dbus_drive_ctrl.sv
`timescale 1ns/1ps
module test_dbus_drive_ctrl;
    import dbus_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ads_n = 1'b1, brdy_n = 1'b1, boff_n = 1'b1, hold = 1'b0;
    logic               cyc_write = 1'b0, cyc_burst = 1'b0, cyc_pipe = 1'b0;
    logic [BE_W-1:0]    cyc_be_n = '1;
    logic [WORDS_W-1:0] cyc_words = '0;
    logic [DBUS_W-1:0]  bus_in = '0;
    logic               bus_oe, rd_valid, hlda;
    logic [DBUS_W-1:0]  bus_dout, rd_data;
    logic [BE_W-1:0]    bus_be_n;
    logic [BEAT_W-1:0]  beat_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    dbus_drive_ctrl i_dbus_drive_ctrl (
        .clk(clk), .rst(rst), .ads_n(ads_n), .brdy_n(brdy_n), .boff_n(boff_n),
        .hold(hold), .cyc_write(cyc_write), .cyc_burst(cyc_burst),
        .cyc_pipe(cyc_pipe), .cyc_be_n(cyc_be_n), .cyc_words(cyc_words),
        .bus_in(bus_in), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .bus_be_n(bus_be_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .beat_cnt(beat_cnt), .hlda(hlda)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [WORDS_W-1:0] rnd_words();
        logic [WORDS_W-1:0] w;
        for (int i = 0; i < BEATS; i++) w[64*i +: 64] = rnd64();
        return w;
    endfunction

    function automatic logic [63:0] word_of(input logic [WORDS_W-1:0] w, input int i);
        return w[64*i +: 64];
    endfunction

    function automatic int beats_of(input logic burst);
        return burst ? BEATS : 1;
    endfunction

    task automatic run_write(input logic burst, input int max_wait);
        logic [WORDS_W-1:0] w = rnd_words();
        logic [BE_W-1:0]    be = BE_W'($urandom);
        ads_n = 0; cyc_write = 1; cyc_burst = burst; cyc_pipe = 0;
        cyc_words = w; cyc_be_n = be;
        step();
        ads_n = 1; cyc_words = rnd_words(); cyc_be_n = BE_W'($urandom);
        chk("R2 launch oe", 64'(bus_oe), 64'd0);
        step();
        chk("R2 drive oe", 64'(bus_oe), 64'd1);
        chk("R2 byte enables", 64'(bus_be_n), 64'(be));
        for (int i = 0; i < beats_of(burst); i++) begin
            int nw = $urandom % (max_wait + 1);
            for (int k = 0; k < nw; k++) begin
                step();
                chk("R3 held word", bus_dout, word_of(w, i));
            end
            chk("R4 beat index", 64'(beat_cnt), 64'(i));
            brdy_n = 0;
            step();
            brdy_n = 1;
            if (i < beats_of(burst) - 1) begin
                chk("R4 next word", bus_dout, word_of(w, i + 1));
            end else begin
                chk("R3 release oe", 64'(bus_oe), 64'd0);
                chk("R11 idle be", 64'(bus_be_n), 64'hFF);
                chk("R4 beat clear", 64'(beat_cnt), 64'd0);
            end
        end
    endtask

    task automatic run_read(input logic burst, input int max_wait);
        ads_n = 0; cyc_write = 0; cyc_burst = burst; cyc_pipe = 0;
        step();
        ads_n = 1;
        chk("R7 read oe", 64'(bus_oe), 64'd0);
        for (int i = 0; i < beats_of(burst); i++) begin
            logic [63:0] v = rnd64();
            int nw = $urandom % (max_wait + 1);
            for (int k = 0; k < nw; k++) begin
                step();
                chk("R5 no pulse while waiting", 64'(rd_valid), 64'd0);
            end
            chk("R5 beat index", 64'(beat_cnt), 64'(i));
            brdy_n = 0; bus_in = v;
            step();
            brdy_n = 1; bus_in = rnd64();
            chk("R5 rd_valid", 64'(rd_valid), 64'd1);
            chk("R5 rd_data", rd_data, v);
            chk("R7 no drive after capture", 64'(bus_oe), 64'd0);
        end
        step();
        chk("R5 pulse one cycle", 64'(rd_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [WORDS_W-1:0] pw;
        logic [63:0] rv;
        void'($urandom(32'h0000_5EED));
        repeat (3) step();
        rst = 0;
        chk("R1 oe", 64'(bus_oe), 64'd0);
        chk("R1 hlda", 64'(hlda), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 beat", 64'(beat_cnt), 64'd0);
        chk("R1 be", 64'(bus_be_n), 64'hFF);

        // R10: ready while idle
        brdy_n = 0; step(); brdy_n = 1;
        chk("R10 idle ready no pulse", 64'(rd_valid), 64'd0);
        chk("R10 idle ready no drive", 64'(bus_oe), 64'd0);

        // R10: ready in launch cycle does not end the write
        pw = rnd_words();
        ads_n = 0; cyc_write = 1; cyc_burst = 0; cyc_words = pw; cyc_be_n = 8'h0F;
        step(); ads_n = 1; brdy_n = 0;
        step();
        chk("R10 launch ready ignored", 64'(bus_oe), 64'd1);
        chk("R2 word0", bus_dout, word_of(pw, 0));
        step(); brdy_n = 1;
        chk("R3 single ends", 64'(bus_oe), 64'd0);

        // directed single and burst
        run_write(1'b0, 2);
        run_write(1'b1, 2);
        run_read(1'b0, 1);
        run_read(1'b1, 1);

        // R6: write pipelined behind a burst read
        ads_n = 0; cyc_write = 0; cyc_burst = 1; cyc_pipe = 0;
        step(); ads_n = 1;
        for (int i = 0; i < BEATS; i++) begin
            if (i == 2) begin
                pw = rnd_words();
                ads_n = 0; cyc_write = 1; cyc_burst = 0; cyc_pipe = 1;
                cyc_words = pw; cyc_be_n = 8'hA5;
                step(); ads_n = 1; cyc_pipe = 0;
                chk("R6 queued write waits", 64'(bus_oe), 64'd0);
            end
            rv = rnd64();
            brdy_n = 0; bus_in = rv;
            step(); brdy_n = 1;
            chk("R5 pipelined read data", rd_data, rv);
        end
        chk("R7 turnaround after last read ready", 64'(bus_oe), 64'd0);
        step();
        chk("R6 queued write drives", 64'(bus_oe), 64'd1);
        chk("R6 queued write word", bus_dout, word_of(pw, 0));
        chk("R6 queued be", 64'(bus_be_n), 64'hA5);
        brdy_n = 0; step(); brdy_n = 1;
        chk("R6 queued write ends", 64'(bus_oe), 64'd0);

        // R6: non-pipelined strobe during a read is ignored
        ads_n = 0; cyc_write = 0; cyc_burst = 0;
        step();
        ads_n = 0; cyc_write = 1; cyc_pipe = 0;
        step(); ads_n = 1;
        brdy_n = 0; step(); brdy_n = 1;
        chk("R5 read done", 64'(rd_valid), 64'd1);
        step();
        chk("R6 unpiped strobe dropped a", 64'(bus_oe), 64'd0);
        step();
        chk("R6 unpiped strobe dropped b", 64'(bus_oe), 64'd0);
        chk("R11 be idle", 64'(bus_be_n), 64'hFF);

        // R8: back-off in the middle of a burst write
        pw = rnd_words();
        ads_n = 0; cyc_write = 1; cyc_burst = 1; cyc_words = pw;
        step(); ads_n = 1;
        step();
        brdy_n = 0; step(); brdy_n = 1;
        chk("R4 second word", bus_dout, word_of(pw, 1));
        boff_n = 0;
        step();
        chk("R8 float", 64'(bus_oe), 64'd0);
        chk("R8 beat reset", 64'(beat_cnt), 64'd0);
        ads_n = 0; cyc_burst = 0; brdy_n = 0;
        step(); ads_n = 1; boff_n = 1; brdy_n = 1;
        step(); step();
        chk("R8 strobe during backoff ignored", 64'(bus_oe), 64'd0);
        brdy_n = 0; step(); brdy_n = 1;
        chk("R8 aborted cycle gone", 64'(rd_valid), 64'd0);
        chk("R8 aborted no drive", 64'(bus_oe), 64'd0);

        // R9: hold granted when idle, strobe ignored
        hold = 1; ads_n = 0; cyc_write = 1;
        step();
        chk("R9 hlda granted", 64'(hlda), 64'd1);
        step();
        chk("R9 float during hold", 64'(bus_oe), 64'd0);
        hold = 0; ads_n = 1;
        step();
        chk("R9 hlda released", 64'(hlda), 64'd0);
        step();
        chk("R9 strobe in hold dropped", 64'(bus_oe), 64'd0);

        // R9: hold deferred while a read is outstanding
        ads_n = 0; cyc_write = 0; cyc_burst = 0;
        step(); ads_n = 1; hold = 1;
        step();
        chk("R9 no grant during read", 64'(hlda), 64'd0);
        brdy_n = 0; step(); brdy_n = 1;
        chk("R9 no grant at read end", 64'(hlda), 64'd0);
        step();
        chk("R9 grant after read", 64'(hlda), 64'd1);
        hold = 0; step();

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic b = 1'($urandom);
            if ($urandom % 2) run_write(b, 3);
            else              run_read(b, 3);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule